// File: doc/BRIEF.md
# Multithreaded Instruction Fetch Unit

This block is the front of a fine-grained multithreaded pipeline. It holds one program counter for each hardware thread. In every clock cycle it grants one thread from the enabled set, rotating fairly among them. It then looks up that thread's PC in a set-associative tag store. The lookup takes two stages. In the first stage, every way reads its tag and line-valid bit for the selected set in parallel. In the second stage, each way compares its tag with the registered request. The second stage reports a fetch (hit) or a cache miss, together with the thread number, the PC and the hit way. A data array outside the block uses these to read the instruction.

PCs are changed in four ways. A job interface loads a new PC into a thread. A rollback request restores a PC for a thread. A miss rewinds the PC by one instruction so that the fetch is retried. Every fetch otherwise advances the PC by 4. Lines arrive through a fill interface, and the block places each one in the pseudo-LRU victim way. The fill stream has a valid strobe but no ready. A fill is accepted in every cycle it is presented, at most one per cycle, and the source never has to wait. The thread-enable bitmap is the only back-pressure on the fetch stream. A thread controller clears a thread's bit while that thread waits for a line, or while its downstream buffer is full.

Top module: `ifu_fetch_top`

## Requirements
- R1: After reset, fetch_valid and cache_miss are low, every thread PC is 0 and every line is invalid.
- R2: A thread is granted only when its enable bit is set. Grants rotate: the search starts at the thread after the last grant, and after reset it starts at thread 0. When no bit is set, no thread is granted.
- R3: The next PC of each thread follows a fixed priority. A job for that thread loads the job PC. Otherwise a rollback request for it loads the rollback PC. Otherwise a stage-2 miss of that thread subtracts 4. Otherwise a grant to that thread adds 4.
- R4: The result for a grant appears exactly one cycle after the grant, with out_tid and out_pc equal to the granted thread and its PC at grant time.
- R5: A way hits when its stored tag equals the request tag and its line is valid. On a hit, fetch_valid is high and out_way names the hitting way.
- R6: cache_miss is high when a granted lookup finds no hitting way.
- R7: While rb_valid is set for the thread shown on out_tid, fetch_valid and cache_miss are both low.
- R8: A fill writes the tag and sets the valid bit of its line in the victim way of its set. The set is the low index bits of fill_line, and the tag is the remaining upper bits.
- R9: If a fill arrives in the same cycle as a lookup of the same line, that lookup hits one cycle later (cut-through).
- R10: Replacement uses a binary pseudo-LRU tree per set. Fills and hits both make their way most recent. From reset, four fills to one set use ways 0, 2, 1, 3, and a fifth fill evicts the least recently used way.
- R11: fetch_valid and cache_miss are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | NTHR | Threads eligible for a grant |
| job_valid | input | 1 | Load a PC into a thread |
| job_tid | input | log2(NTHR) | Thread that receives the job |
| job_pc | input | AW | PC to load |
| rb_valid | input | NTHR | Rollback request per thread |
| rb_pc | input | NTHR*AW | Restore PC per thread, thread i in bits i*AW upward |
| fill_valid | input | 1 | A line arrives this cycle |
| fill_line | input | AW-log2(LINE_BYTES) | Line address of the arriving line |
| fetch_valid | output | 1 | Stage-2 lookup hit |
| cache_miss | output | 1 | Stage-2 lookup missed |
| out_tid | output | log2(NTHR) | Thread of the stage-2 lookup |
| out_pc | output | AW | PC of the stage-2 lookup |
| out_way | output | log2(NWAY) | Way that hit |

## Verification
Two functions can fall in the same cycle and must both take effect: a fill, and a first-stage lookup of that same line. The bench answers each miss with a fill exactly three cycles later while four threads rotate. Because of this, the fill lands in the cycle the missing thread comes back for its retry. The retry is judged correct only if it hits without a second miss. A job and a rollback aimed at the same thread in one cycle are also provoked, and the thread's later fetched PCs show which one won.

// File: rtl/ifu_pkg.sv
`timescale 1ns/1ps
package ifu_pkg;
  localparam int PC_STEP = 4;
  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_ADV,
    SRC_REWIND,
    SRC_ROLLBACK,
    SRC_JOB
  } pc_src_e;
endpackage

// File: rtl/ifu_rr_arb.sv
`timescale 1ns/1ps
module ifu_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_id
);
  logic [IW-1:0] ptr_q;
  logic          armed_q;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_id  = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!gnt_vld && req[idx]) begin
        gnt_vld = 1'b1;
        gnt_id  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (gnt_vld) ptr_q <= (int'(gnt_id) == N - 1) ? '0 : gnt_id + 1'b1;
    end
  end

  // R2: only enabled threads are granted
  p_grant_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> req[gnt_id]);
  // R2: with a steady multi-thread mask, consecutive grants differ
  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && gnt_vld && $past(gnt_vld) && $countones(req) > 1 && req == $past(req))
      |-> gnt_id != $past(gnt_id));
endmodule

// File: rtl/ifu_pc_file.sv
`timescale 1ns/1ps
module ifu_pc_file #(
  parameter int NTHR = 4,
  parameter int AW   = 32,
  localparam int TW  = $clog2(NTHR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_valid,
  input  logic [TW-1:0]    job_tid,
  input  logic [AW-1:0]    job_pc,
  input  logic [NTHR-1:0]  rb_valid,
  input  logic [NTHR*AW-1:0] rb_pc,
  input  logic             rew_valid,
  input  logic [TW-1:0]    rew_tid,
  input  logic             adv_valid,
  input  logic [TW-1:0]    adv_tid,
  output logic [NTHR*AW-1:0] pc_flat
);
  import ifu_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(PC_STEP);

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    pc_src_e       src;
    logic [AW-1:0] pc_q;

    always_comb begin
      if (job_valid && job_tid == TW'(i))      src = SRC_JOB;
      else if (rb_valid[i])                    src = SRC_ROLLBACK;
      else if (rew_valid && rew_tid == TW'(i)) src = SRC_REWIND;
      else if (adv_valid && adv_tid == TW'(i)) src = SRC_ADV;
      else                                     src = SRC_HOLD;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= '0;
      else begin
        case (src)
          SRC_JOB:      pc_q <= job_pc;
          SRC_ROLLBACK: pc_q <= rb_pc[i*AW +: AW];
          SRC_REWIND:   pc_q <= pc_q - STEP;
          SRC_ADV:      pc_q <= pc_q + STEP;
          default:      pc_q <= pc_q;
        endcase
      end
    end

    assign pc_flat[i*AW +: AW] = pc_q;

    // R3: a job outranks every other source
    p_job_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (job_valid && job_tid == TW'(i)) |=> pc_q == $past(job_pc));
    // R3: a rollback outranks rewind and advance
    p_rb_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_valid[i] && !(job_valid && job_tid == TW'(i))) |=> pc_q == $past(rb_pc[i*AW +: AW]));
  end
endmodule

// File: rtl/ifu_tag_way.sv
`timescale 1ns/1ps
module ifu_tag_way #(
  parameter int NSET = 128,
  parameter int TAGW = 19,
  localparam int IW  = $clog2(NSET)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [IW-1:0]   rd_idx,
  input  logic [TAGW-1:0] rd_tag,
  input  logic            fill_we,
  input  logic [IW-1:0]   fill_idx,
  input  logic [TAGW-1:0] fill_tag,
  output logic [TAGW-1:0] tag_q,
  output logic            vld_q
);
  logic [TAGW-1:0] tag_mem [NSET];
  logic [NSET-1:0] vld_mem;
  logic            same_set;
  logic            armed_q;

  assign same_set = fill_we && fill_idx == rd_idx;

  always_ff @(posedge clk) begin
    if (fill_we) tag_mem[fill_idx] <= fill_tag;
    tag_q <= same_set ? fill_tag : tag_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_mem <= '0;
      vld_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (fill_we) vld_mem[fill_idx] <= 1'b1;
      vld_q <= same_set ? 1'b1 : (vld_mem[rd_idx] & rd_en);
    end
  end

  // R8: a fill leaves its line valid
  p_fill_sets_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(fill_we)) |-> vld_mem[$past(fill_idx)]);
  // R9: a fill of the line being read is visible to that read
  p_cut_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(fill_we && rd_en && fill_idx == rd_idx && fill_tag == rd_tag))
      |-> (vld_q && tag_q == $past(rd_tag)));
endmodule

// File: rtl/ifu_plru.sv
`timescale 1ns/1ps
module ifu_plru #(
  parameter int NSET = 128,
  parameter int NWAY = 4,
  localparam int IW  = $clog2(NSET),
  localparam int WW  = $clog2(NWAY),
  localparam int TB  = NWAY - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_en,
  input  logic [IW-1:0] hit_idx,
  input  logic [WW-1:0] hit_way,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_idx,
  output logic [WW-1:0] victim
);
  logic [TB-1:0] tree_q [NSET];
  logic          armed_q;

  function automatic logic [WW-1:0] pick(input logic [TB-1:0] t);
    logic [WW-1:0] w;
    int n;
    n = 0;
    for (int l = 0; l < WW; l++) begin
      w[WW-1-l] = t[n];
      n = 2 * n + 1 + int'(t[n]);
    end
    return w;
  endfunction

  function automatic logic [TB-1:0] touch(input logic [TB-1:0] t, input logic [WW-1:0] w);
    logic [TB-1:0] r;
    int n;
    r = t;
    n = 0;
    for (int l = 0; l < WW; l++) begin
      r[n] = ~w[WW-1-l];
      n = 2 * n + 1 + int'(w[WW-1-l]);
    end
    return r;
  endfunction

  assign victim = pick(tree_q[fill_idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      for (int s = 0; s < NSET; s++) tree_q[s] <= '0;
    end else begin
      armed_q <= 1'b1;
      if (fill_en && hit_en && fill_idx == hit_idx)
        tree_q[fill_idx] <= touch(touch(tree_q[fill_idx], victim), hit_way);
      else begin
        if (fill_en) tree_q[fill_idx] <= touch(tree_q[fill_idx], victim);
        if (hit_en)  tree_q[hit_idx]  <= touch(tree_q[hit_idx], hit_way);
      end
    end
  end

  // R10: the way just filled is not the next victim of its set
  p_fill_mru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(fill_en && !hit_en)) |-> pick(tree_q[$past(fill_idx)]) != $past(victim));
  // R10: the way just hit is not the next victim of its set
  p_hit_mru_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(hit_en && !fill_en)) |-> pick(tree_q[$past(hit_idx)]) != $past(hit_way));
endmodule

// File: rtl/ifu_fetch_top.sv
`timescale 1ns/1ps
module ifu_fetch_top #(
  parameter int NTHR       = 4,
  parameter int NWAY       = 4,
  parameter int NSET       = 128,
  parameter int LINE_BYTES = 64,
  parameter int AW         = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NTHR-1:0]                     thr_en,
  input  logic                                job_valid,
  input  logic [$clog2(NTHR)-1:0]             job_tid,
  input  logic [AW-1:0]                       job_pc,
  input  logic [NTHR-1:0]                     rb_valid,
  input  logic [NTHR*AW-1:0]                  rb_pc,
  input  logic                                fill_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0]    fill_line,
  output logic                                fetch_valid,
  output logic                                cache_miss,
  output logic [$clog2(NTHR)-1:0]             out_tid,
  output logic [AW-1:0]                       out_pc,
  output logic [$clog2(NWAY)-1:0]             out_way
);
  localparam int TW   = $clog2(NTHR);
  localparam int WW   = $clog2(NWAY);
  localparam int IW   = $clog2(NSET);
  localparam int OW   = $clog2(LINE_BYTES);
  localparam int TAGW = AW - OW - IW;

  logic                  gnt_vld;
  logic [TW-1:0]         gnt_id;
  logic [NTHR*AW-1:0]    pc_flat;
  logic [AW-1:0]         s0_pc;
  logic [IW-1:0]         s0_idx;
  logic [TAGW-1:0]       s0_tag;
  logic [IW-1:0]         fill_idx;
  logic [TAGW-1:0]       fill_tag;
  logic [WW-1:0]         victim;

  logic                  s1_valid;
  logic [TW-1:0]         s1_tid;
  logic [AW-1:0]         s1_pc;
  logic [TAGW-1:0]       s1_tag;
  logic [IW-1:0]         s1_idx;
  logic [NWAY-1:0]       hit;
  logic                  hit_any;
  logic [WW-1:0]         hit_way;
  logic                  miss_int;
  logic                  rb_s1;
  logic                  armed_q;

  ifu_rr_arb #(.N(NTHR)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(thr_en), .gnt_vld(gnt_vld), .gnt_id(gnt_id)
  );

  assign s0_pc    = pc_flat[gnt_id*AW +: AW];
  assign s0_idx   = s0_pc[OW +: IW];
  assign s0_tag   = s0_pc[AW-1 -: TAGW];
  assign fill_idx = fill_line[IW-1:0];
  assign fill_tag = fill_line[AW-OW-1 -: TAGW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_tid   <= '0;
      s1_pc    <= '0;
      armed_q  <= 1'b0;
    end else begin
      armed_q  <= 1'b1;
      s1_valid <= gnt_vld;
      s1_tid   <= gnt_id;
      s1_pc    <= s0_pc;
    end
  end

  assign s1_tag = s1_pc[AW-1 -: TAGW];
  assign s1_idx = s1_pc[OW +: IW];

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    logic [TAGW-1:0] tag_q;
    logic            vld_q;
    ifu_tag_way #(.NSET(NSET), .TAGW(TAGW)) u_way (
      .clk(clk), .rst_n(rst_n),
      .rd_en(gnt_vld), .rd_idx(s0_idx), .rd_tag(s0_tag),
      .fill_we(fill_valid && victim == WW'(w)),
      .fill_idx(fill_idx), .fill_tag(fill_tag),
      .tag_q(tag_q), .vld_q(vld_q)
    );
    assign hit[w] = vld_q && tag_q == s1_tag;
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < NWAY; w++) if (hit[w]) hit_way = WW'(w);
  end
  assign hit_any  = |hit;
  assign miss_int = s1_valid && !hit_any;
  assign rb_s1    = rb_valid[s1_tid];

  ifu_plru #(.NSET(NSET), .NWAY(NWAY)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .hit_en(s1_valid && hit_any), .hit_idx(s1_idx), .hit_way(hit_way),
    .fill_en(fill_valid), .fill_idx(fill_idx), .victim(victim)
  );

  ifu_pc_file #(.NTHR(NTHR), .AW(AW)) u_pc (
    .clk(clk), .rst_n(rst_n),
    .job_valid(job_valid), .job_tid(job_tid), .job_pc(job_pc),
    .rb_valid(rb_valid), .rb_pc(rb_pc),
    .rew_valid(miss_int), .rew_tid(s1_tid),
    .adv_valid(gnt_vld), .adv_tid(gnt_id),
    .pc_flat(pc_flat)
  );

  assign fetch_valid = s1_valid && !rb_s1 && hit_any;
  assign cache_miss  = s1_valid && !rb_s1 && !hit_any;
  assign out_tid     = s1_tid;
  assign out_pc      = s1_pc;
  assign out_way     = hit_way;

  // R11: hit and miss indications are exclusive
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && cache_miss));
  // R4: any result belongs to the grant of the previous cycle
  p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid || cache_miss) |-> (armed_q && $past(gnt_vld) && out_tid == $past(gnt_id)));
  // R5: at most one way matches a lookup
  p_hit_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> $onehot0(hit));
endmodule

// File: tb/sim_ifu_fetch_top.sv
`timescale 1ns/1ps
module sim_ifu_fetch_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  thr_en;
  logic        job_valid;
  logic [1:0]  job_tid;
  logic [15:0] job_pc;
  logic [3:0]  rb_valid;
  logic [63:0] rb_pc;
  logic        fill_valid;
  logic [11:0] fill_line;
  logic        fetch_valid, cache_miss;
  logic [1:0]  out_tid, out_way;
  logic [15:0] out_pc;

  int checks = 0;
  int errors = 0;

  ifu_fetch_top #(.NTHR(4), .NWAY(4), .NSET(4), .LINE_BYTES(16), .AW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_en(thr_en),
    .job_valid(job_valid), .job_tid(job_tid), .job_pc(job_pc),
    .rb_valid(rb_valid), .rb_pc(rb_pc),
    .fill_valid(fill_valid), .fill_line(fill_line),
    .fetch_valid(fetch_valid), .cache_miss(cache_miss),
    .out_tid(out_tid), .out_pc(out_pc), .out_way(out_way)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    thr_en = '0; job_valid = 1'b0; job_tid = '0; job_pc = '0;
    rb_valid = '0; rb_pc = '0; fill_valid = 1'b0; fill_line = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // start of a cycle: inputs back to idle, caller sets the rest
  task automatic cyc();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic give_job(input int t, input int pc);
    cyc();
    job_valid = 1'b1; job_tid = 2'(t); job_pc = 16'(pc);
  endtask

  task automatic give_fill(input int line);
    cyc();
    fill_valid = 1'b1; fill_line = 12'(line);
  endtask

  int pcm [4];
  int sched_pc [0:127];
  int fill_at [0:127];
  int lv_cyc [0:4095];

  initial begin
    rst_n = 1'b0;
    idle_inputs();

    // ---------------- reset state and cold miss
    do_reset();
    cyc(); #1;
    chk("R1", "fetch_valid after reset", fetch_valid, 0);
    chk("R1", "cache_miss after reset", cache_miss, 0);
    cyc(); thr_en = 4'b0100; #1;
    chk("R4", "no result in grant cycle", fetch_valid | cache_miss, 0);
    cyc(); #1;
    chk("R1", "reset PC of thread 2", out_pc, 0);
    chk("R4", "tid of result", out_tid, 2);
    chk("R6", "cold lookup misses", cache_miss, 1);
    chk("R1", "no line valid after reset", fetch_valid, 0);
    cyc(); #1;
    chk("R2", "no grant with empty mask", fetch_valid | cache_miss, 0);

    // ---------------- round robin over a sparse mask
    do_reset();
    for (int k = 0; k < 8; k++) begin
      cyc();
      if (k < 6) thr_en = 4'b1010;
      #1;
      if (k >= 1 && k <= 6) begin
        chk("R2", "rotating grant tid", out_tid, (k % 2 == 1) ? 1 : 3);
        chk("R2", "granted thread produces a result", fetch_valid | cache_miss, 1);
      end else begin
        chk("R2", "no result without grant", fetch_valid | cache_miss, 0);
      end
    end

    // ---------------- replacement order, hit recency
    do_reset();
    give_fill('h00); give_fill('h10); give_fill('h20); give_fill('h30);
    give_fill('h40);                      // evicts way 0 (line 0x00)
    for (int t = 0; t < 4; t++) give_job(t, t * 'h100);
    for (int k = 0; k < 5; k++) begin
      cyc();
      if (k < 4) thr_en = 4'hF;
      #1;
      if (k == 1) chk("R10", "fifth fill evicted oldest line", cache_miss, 1);
      if (k == 2) begin chk("R8", "line 0x10 hit", fetch_valid, 1); chk("R10", "way of line 0x10", out_way, 2); end
      if (k == 3) begin chk("R8", "line 0x20 hit", fetch_valid, 1); chk("R10", "way of line 0x20", out_way, 1); end
      if (k == 4) begin chk("R5", "line 0x30 hit", fetch_valid, 1); chk("R10", "way of line 0x30", out_way, 3); end
    end
    give_fill('h50);                      // hits made way 0 least recent
    for (int t = 0; t < 4; t++) give_job(t, t * 'h100 + ((t == 0) ? 'h400 : 0));
    for (int k = 0; k < 5; k++) begin
      cyc();
      if (k < 4) thr_en = 4'hF;
      #1;
      if (k == 1) chk("R10", "hits steer victim: line 0x40 gone", cache_miss, 1);
      if (k == 2) begin chk("R10", "line 0x10 kept", fetch_valid, 1); chk("R5", "way of line 0x10", out_way, 2); end
      if (k == 3) chk("R10", "line 0x20 kept", fetch_valid, 1);
      if (k == 4) chk("R10", "line 0x30 kept", fetch_valid, 1);
    end

    // ---------------- four-thread sweep with fills, jobs and rollbacks
    do_reset();
    for (int t = 0; t < 4; t++) begin give_job(t, t * 'h100); pcm[t] = t * 'h100; end
    for (int i = 0; i < 128; i++) begin fill_at[i] = -1; sched_pc[i] = 0; end
    for (int i = 0; i < 4096; i++) lv_cyc[i] = -1;
    for (int c = 0; c < 64; c++) begin
      int jt, jp;
      bit jv;
      cyc();
      thr_en = 4'hF;
      jv = 1'b0; jt = 0; jp = 0;
      if (c == 20) begin jv = 1'b1; jt = 2; jp = 'h204; rb_valid[2] = 1'b1; rb_pc[2*16 +: 16] = 16'h0200; end
      if (c == 30) begin rb_valid[1] = 1'b1; rb_pc[1*16 +: 16] = 16'h0100; end
      if (c == 41) begin rb_valid[0] = 1'b1; rb_pc[0 +: 16] = 16'h0000; end
      if (c == 45) begin jv = 1'b1; jt = 3; jp = 'h320; end
      job_valid = jv; job_tid = 2'(jt); job_pc = 16'(jp);
      if (fill_at[c] >= 0) begin
        fill_valid = 1'b1; fill_line = 12'(fill_at[c]); lv_cyc[fill_at[c]] = c;
      end
      #1;
      sched_pc[c] = pcm[c % 4];
      if (c == 0) chk("R4", "sweep start quiet", fetch_valid | cache_miss, 0);
      else begin
        int ot, ep, ln;
        bit hit, quiet;
        ot = (c - 1) % 4; ep = sched_pc[c - 1]; ln = ep >> 4;
        hit = lv_cyc[ln] >= 0 && lv_cyc[ln] <= c - 1;
        quiet = rb_valid[ot];
        chk("R4", "sweep tid", out_tid, ot);
        chk("R3", "sweep fetched PC", out_pc, ep);
        if (quiet) begin
          chk("R7", "rollback hides fetch", fetch_valid, 0);
          chk("R7", "rollback hides miss", cache_miss, 0);
        end else begin
          if (hit && lv_cyc[ln] == c - 1) chk("R9", "cut-through hit", fetch_valid, 1);
          else chk("R5", "hit per filled line", fetch_valid, hit);
          chk("R6", "miss per unfilled line", cache_miss, !hit);
          if (!hit && lv_cyc[ln] == -1 && c + 3 < 128) begin
            fill_at[c + 3] = ln; lv_cyc[ln] = -2;
          end
        end
        // R3 priority model for the edge ending this cycle
        for (int i = 0; i < 4; i++) begin
          if (jv && jt == i) pcm[i] = jp;
          else if (rb_valid[i]) pcm[i] = int'(rb_pc[i*16 +: 16]);
          else if (i == ot && !hit) pcm[i] = (pcm[i] - 4) & 'hFFFF;
          else if (i == c % 4) pcm[i] = (pcm[i] + 4) & 'hFFFF;
        end
      end
      if (c == 0) pcm[0] = pcm[0] + 4;
    end
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule